// File: doc/BRIEF.md
# Excess-Six Packed BCD Adder

This block adds two packed BCD numbers and a carry-in, and returns a packed BCD sum with a decimal carry-out. It contains no compare-against-nine decimal fix-up. Instead, it biases every digit of the first operand by plus six, runs a plain binary add, and then removes the bias from every result digit that did not overflow its four bits.

Each digit of the first operand holds 0 to 9. After the bias it holds 6 to 15, so the bias never produces a carry. In the binary add, a digit overflows exactly when its true decimal sum reaches ten. A digit that overflowed is already correct modulo sixteen. A digit that did not overflow still carries the bias, and subtracting six inside that digit removes it. The block is purely combinational, and the digit count is a parameter.

The encoding is packed BCD: digit k occupies bits [4k+3:4k], and the least significant decimal digit sits in bits [3:0]. Operands are assumed to hold valid BCD digits (0 to 9).

Top module: `xs6_bcd_adder`

## Requirements
- R1: The low sum digit `sum[3:0]` equals (opa[3:0] + opb[3:0] + cin) mod 10 for valid BCD operands.
- R2: The full sum read as packed BCD equals (value(opa) + value(opb) + cin) mod 10^NDIGITS, where value() reads each 4-bit digit as a decimal digit with the low digit in bits [3:0].
- R3: `cout` is 1 exactly when value(opa) + value(opb) + cin is at least 10^NDIGITS.
- R4: `cin` = 1 adds exactly one to the decimal result compared with `cin` = 0 for the same operands.
- R5: A low digit whose decimal sum reaches ten passes a carry into the next digit, for example 09 + 00 + 1 = 10.
- R6: The removal of the bias stays within each digit and never borrows from a neighbour, for example 00 + 00 + 0 = 00 even though every raw digit holds six.
- R7: Every sum digit is at most 9 whenever both operands are valid BCD.
- R8: The largest input case, 99 + 99 + 1, gives sum 99 with `cout` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4*NDIGITS | First packed BCD operand; this operand is biased by plus six per digit |
| opb | input | 4*NDIGITS | Second packed BCD operand |
| cin | input | 1 | Decimal carry-in, added at bit 0 |
| sum | output | 4*NDIGITS | Packed BCD sum |
| cout | output | 1 | Decimal carry-out from the top digit |

## Verification
The bench builds the adder with the default NDIGITS = 2. At that width the whole valid input space is small: 100 × 100 operand pairs times two carry-in values, or 20,000 cases. The bench therefore walks every one of them against a decimal model computed from integers. This covers every pattern of digit carries, including the chain where a low-digit overflow lifts a 9 in the upper digit into a decimal carry-out. A vector table and directed cases then aim at the carry-in, the no-borrow bias removal and the all-nines limit.

// File: rtl/xs6_pkg.sv
package xs6_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] XS_BIAS = 4'd6;
    localparam logic [DIGIT_W-1:0] DEC_MAX = 4'd9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   carry;
        digit_t val;
    } digit_res_t;

    function automatic digit_t bias_up(digit_t d);
        return d + XS_BIAS;
    endfunction

    function automatic digit_t bias_down(digit_t d);
        return d - XS_BIAS;
    endfunction

    function automatic logic is_dec(digit_t d);
        return d <= DEC_MAX;
    endfunction

    function automatic int pow10(int n);
        int p;
        p = 1;
        for (int i = 0; i < n; i++) p = p * 10;
        return p;
    endfunction

endpackage

// File: rtl/xs6_pre.sv
module xs6_pre
    import xs6_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [W-1:0] opnd,
    output logic [W-1:0] biased
);
    for (genvar g = 0; g < NDIGITS; g++) begin : g_dig
        // each digit biased on its own; no carry leaves the slice
        assign biased[g*DIGIT_W +: DIGIT_W] = bias_up(opnd[g*DIGIT_W +: DIGIT_W]);
    end
endmodule

// File: rtl/xs6_binadd.sv
module xs6_binadd
    import xs6_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [W-1:0]       x,
    input  logic [W-1:0]       y,
    input  logic               cin,
    output logic [W-1:0]       raw,
    output logic [NDIGITS-1:0] dcarry
);
    logic [NDIGITS:0] chain;
    assign chain[0] = cin;

    for (genvar g = 0; g < NDIGITS; g++) begin : g_dig
        digit_res_t r;
        assign r = {1'b0, x[g*DIGIT_W +: DIGIT_W]}
                 + {1'b0, y[g*DIGIT_W +: DIGIT_W]}
                 + {4'd0, chain[g]};
        assign raw[g*DIGIT_W +: DIGIT_W] = r.val;
        assign dcarry[g]  = r.carry;
        assign chain[g+1] = r.carry;
    end
endmodule

// File: rtl/xs6_post.sv
module xs6_post
    import xs6_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [W-1:0]       raw,
    input  logic [NDIGITS-1:0] dcarry,
    output logic [W-1:0]       fixed
);
    for (genvar g = 0; g < NDIGITS; g++) begin : g_dig
        digit_t d;
        assign d = raw[g*DIGIT_W +: DIGIT_W];
        // subtraction wraps inside the digit, no borrow to the neighbour
        assign fixed[g*DIGIT_W +: DIGIT_W] = dcarry[g] ? d : bias_down(d);
    end
endmodule

// File: rtl/xs6_bcd_adder.sv
module xs6_bcd_adder
    import xs6_pkg::*;
#(
    parameter int NDIGITS = 2,
    localparam int W = NDIGITS * DIGIT_W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int MODULUS = pow10(NDIGITS);

    logic [W-1:0]       a_biased;
    logic [W-1:0]       raw;
    logic [NDIGITS-1:0] dcarry;

    xs6_pre #(.NDIGITS(NDIGITS)) u_pre (
        .opnd   (opa),
        .biased (a_biased)
    );

    xs6_binadd #(.NDIGITS(NDIGITS)) u_add (
        .x      (a_biased),
        .y      (opb),
        .cin    (cin),
        .raw    (raw),
        .dcarry (dcarry)
    );

    xs6_post #(.NDIGITS(NDIGITS)) u_post (
        .raw    (raw),
        .dcarry (dcarry),
        .fixed  (sum)
    );

    assign cout = dcarry[NDIGITS-1];

    // decimal cross-checks of the assembled datapath
    always_comb begin
        logic in_ok;
        logic out_ok;
        logic floor_ok;
        int   va, vb, vs, wt, tot, lo;
        in_ok    = 1'b1;
        out_ok   = 1'b1;
        floor_ok = 1'b1;
        va = 0; vb = 0; vs = 0; wt = 1;
        for (int i = 0; i < NDIGITS; i++) begin
            in_ok  = in_ok & is_dec(opa[i*DIGIT_W +: DIGIT_W]) & is_dec(opb[i*DIGIT_W +: DIGIT_W]);
            out_ok = out_ok & is_dec(sum[i*DIGIT_W +: DIGIT_W]);
            if (!dcarry[i] && raw[i*DIGIT_W +: DIGIT_W] < XS_BIAS) floor_ok = 1'b0;
            va = va + wt * int'(opa[i*DIGIT_W +: DIGIT_W]);
            vb = vb + wt * int'(opb[i*DIGIT_W +: DIGIT_W]);
            vs = vs + wt * int'(sum[i*DIGIT_W +: DIGIT_W]);
            wt = wt * 10;
        end
        tot = va + vb + int'(cin);
        lo  = (int'(opa[DIGIT_W-1:0]) + int'(opb[DIGIT_W-1:0]) + int'(cin)) % 10;
        if (in_ok) begin
            p_digit_range_r7: assert (out_ok)
                else $error("R7: sum digit above nine");
            p_low_digit_r1: assert (int'(sum[DIGIT_W-1:0]) == lo)
                else $error("R1: low digit wrong");
            p_sum_value_r2: assert (vs == tot % MODULUS)
                else $error("R2: sum value wrong");
            p_carry_out_r3: assert (cout == (tot >= MODULUS))
                else $error("R3: decimal carry wrong");
            p_no_borrow_r6: assert (floor_ok)
                else $error("R6: uncarried raw digit below bias");
        end
    end

endmodule

// File: tb/tb_xs6_bcd_adder.sv
module tb_xs6_bcd_adder;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] opa, opb, sum;
    logic       cin, cout;

    int total = 0;
    int bad   = 0;

    xs6_bcd_adder #(.NDIGITS(2)) dut (
        .opa  (opa),
        .opb  (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    // {opa, opb, cin, expected sum, expected cout}
    localparam int NVEC = 8;
    localparam logic [25:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 1'b0, 8'h00, 1'b0},
        {8'h05, 8'h03, 1'b1, 8'h09, 1'b0},
        {8'h09, 8'h00, 1'b1, 8'h10, 1'b0},
        {8'h45, 8'h38, 1'b0, 8'h83, 1'b0},
        {8'h50, 8'h50, 1'b0, 8'h00, 1'b1},
        {8'h99, 8'h01, 1'b0, 8'h00, 1'b1},
        {8'h99, 8'h99, 1'b1, 8'h99, 1'b1},
        {8'h27, 8'h73, 1'b1, 8'h01, 1'b1}
    };

    function automatic logic [7:0] to_bcd(int v);
        return {4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c);
        @(negedge clk);
        opa = a; opb = b; cin = c;
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] es, input logic ec);
        total++;
        if (sum !== es || cout !== ec) begin
            bad++;
            $display("FAIL %s: a=%h b=%h cin=%0b actual sum=%h cout=%0b expected sum=%h cout=%0b",
                     req, opa, opb, cin, sum, cout, es, ec);
        end
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        opa = '0; opb = '0; cin = 1'b0;
        // R6: all-zero input leaves raw digits at six; bias removed without borrow
        apply(8'h00, 8'h00, 1'b0);
        check("R6", 8'h00, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][25:18], VEC[i][17:10], VEC[i][9]);
            check("R2/R3 table", VEC[i][8:1], VEC[i][0]);
        end

        // R1 R2 R3 R7: exhaustive decimal sweep
        for (int ia = 0; ia < 100; ia++) begin
            for (int ib = 0; ib < 100; ib++) begin
                for (int c = 0; c < 2; c++) begin
                    int t;
                    t = ia + ib + c;
                    apply(to_bcd(ia), to_bcd(ib), c[0]);
                    check("R1/R2/R3/R7", to_bcd(t % 100), t >= 100);
                end
            end
        end

        // R4: carry-in adds one
        apply(8'h36, 8'h21, 1'b0);
        check("R4", 8'h57, 1'b0);
        apply(8'h36, 8'h21, 1'b1);
        check("R4", 8'h58, 1'b0);
        // R5: low-digit carry into the upper digit, and onward to cout
        apply(8'h09, 8'h00, 1'b1);
        check("R5", 8'h10, 1'b0);
        apply(8'h19, 8'h80, 1'b1);
        check("R5", 8'h00, 1'b1);
        // R6: uncarried digits both corrected independently
        apply(8'h12, 8'h34, 1'b0);
        check("R6", 8'h46, 1'b0);
        // R8: largest case
        apply(8'h99, 8'h99, 1'b1);
        check("R8", 8'h99, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule